// File: doc/BRIEF.md
# Bus Read Latency and Transfer Performance Monitor

This block watches the strobes of a bus master port and keeps two running totals that software can sample. The first total is read latency: the number of bus clocks during which at least one read command is waiting for its data, summed over every read since the last sample. The second total is transfer volume: the number of double words that crossed the bus in master data transactions, one per data-valid beat.

Both totals are packed into a single 32-bit status word. The latency total sits in the upper half, the beat total in the lowest byte, and the byte between them is always zero. A host read strobe samples the word and starts a new measurement interval, so each read reports only the activity since the previous one. The counters stop at their maximum values rather than wrapping, and an event that coincides with the sampling read is kept for the next interval. Writes to the word have no effect.

Top module: `rd_lat_perfmon`

## Requirements
- R1: After reset the status word reads as all zeros.
- R2: The latency field, bits 31 to 16, increases by one in every clock cycle in which a read is outstanding, counting from the cycle of `rd_req` through the cycle of the matching `rd_done`, both inclusive; a request and completion in the same cycle counts one.
- R3: Bits 15 to 8 of the status word are zero at all times.
- R4: The beat field, bits 7 to 0, increases by one for each cycle in which `beat_vld` is high.
- R5: In a cycle with `reg_rd` high, `reg_rdata` shows the totals gathered so far, and both fields restart from zero in the following cycle.
- R6: Each field holds at its all-ones value (65535 for latency, 255 for beats) once reached, and does not wrap.
- R7: A latency cycle or a beat occurring in the same cycle as `reg_rd` is counted into the new interval, so the field reads one afterwards.
- R8: With several reads outstanding at once (up to 15), the latency field still advances by exactly one per clock, not once per outstanding read.
- R9: A cycle with `reg_wr` high and `reg_rd` low leaves both fields unchanged apart from counting events in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | One-cycle pulse when a read command is raised |
| rd_done | input | 1 | One-cycle pulse when a read access completes |
| beat_vld | input | 1 | High for each double word moved by the master |
| reg_rd | input | 1 | Host read strobe for the status word |
| reg_wr | input | 1 | Host write strobe for the status word (ignored) |
| reg_rdata | output | 32 | Status word: latency in 31:16, zero in 15:8, beats in 7:0 |

## Verification
The assertions assume the bus keeps read accounting consistent: a completion never arrives with no read outstanding unless a request arrives in the same cycle, and no more than 15 reads are ever in flight. The random stimulus enforces this by tracking the outstanding count in the bench, raising `rd_done` only when a read is waiting and withholding `rd_req` when the limit is reached. Directed sequences cover back-to-back and overlapping reads, sampling reads coinciding with events, ignored writes and both saturation limits.

// File: rtl/rlpm_pkg.sv
`timescale 1ns/1ps
package rlpm_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] stat_word_t;
endpackage

// File: rtl/rlpm_track.sv
`timescale 1ns/1ps
// Tracks how many reads are in flight and flags latency cycles.
module rlpm_track #(
  parameter int unsigned OUTST_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic rd_done,
  output logic busy
);
  localparam logic [OUTST_W-1:0] OUTST_MAX = {OUTST_W{1'b1}};

  logic [OUTST_W-1:0] outst_q;
  logic [OUTST_W-1:0] outst_d;
  logic               outst_en;

  always_comb begin
    outst_en = rd_req ^ rd_done;
    outst_d  = outst_q;
    if (rd_req && !rd_done) begin
      outst_d = outst_q + OUTST_W'(1);
    end else if (rd_done && !rd_req) begin
      outst_d = outst_q - OUTST_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
    end else if (outst_en) begin
      outst_q <= outst_d;
    end
  end

  // A read costs latency from its request cycle through its completion cycle.
  assign busy = rd_req | (outst_q != '0);

  // Input contract: completions only for reads that exist.
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (rd_req || outst_q != '0));

  // Input contract: in-flight reads stay within the tracked range.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |-> (outst_q != OUTST_MAX));

endmodule

// File: rtl/rlpm_satcnt.sv
`timescale 1ns/1ps
// Saturating event counter with a clear that keeps a coincident event.
module rlpm_satcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] base;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    base  = clr ? '0 : cnt_q;
    cnt_d = base;
    if (inc && base != CNT_MAX) begin
      cnt_d = base + W'(1);
    end
    cnt_en = clr | inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

  assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/rd_lat_perfmon.sv
`timescale 1ns/1ps
module rd_lat_perfmon
  import rlpm_pkg::*;
#(
  parameter int unsigned CLK_W   = 16,
  parameter int unsigned DW_W    = 8,
  parameter int unsigned OUTST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_done,
  input  logic              beat_vld,
  input  logic              reg_rd,
  input  logic              reg_wr,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int unsigned LAT_LO = WORD_W - CLK_W;
  localparam int unsigned RSV_HI = LAT_LO - 1;
  localparam int unsigned RSV_LO = DW_W;

  logic             busy;
  logic [CLK_W-1:0] lat_cnt;
  logic [DW_W-1:0]  beat_cnt;
  stat_word_t       word;

  rlpm_track #(.OUTST_W(OUTST_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_done (rd_done),
    .busy    (busy)
  );

  rlpm_satcnt #(.W(CLK_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reg_rd),
    .inc   (busy),
    .cnt_q (lat_cnt)
  );

  rlpm_satcnt #(.W(DW_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reg_rd),
    .inc   (beat_vld),
    .cnt_q (beat_cnt)
  );

  always_comb begin
    word = '0;
    word[WORD_W-1:LAT_LO] = lat_cnt;
    word[DW_W-1:0]        = beat_cnt;
  end

  assign reg_rdata = word;

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RSV_HI:RSV_LO] == '0);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_rdata[WORD_W-1:LAT_LO] <= CLK_W'(1) &&
                reg_rdata[DW_W-1:0] <= DW_W'(1)));

  assert_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && !busy && !beat_vld) |=> $stable(reg_rdata));

endmodule

// File: tb/sim_rd_lat_perfmon.sv
`timescale 1ns/1ps
module sim_rd_lat_perfmon;
  logic        clk;
  logic        rst_n;
  logic        rd_req, rd_done, beat_vld, reg_rd, reg_wr;
  logic [31:0] reg_rdata;

  int unsigned checks = 0;
  int unsigned errors = 0;

  int unsigned m_outst = 0;
  int unsigned m_lat   = 0;
  int unsigned m_beat  = 0;

  rd_lat_perfmon u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_done(rd_done),
    .beat_vld(beat_vld), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] exp_word();
    return {m_lat[15:0], 8'h00, m_beat[7:0]};
  endfunction

  function automatic int unsigned sat_add(int unsigned base, bit inc, int unsigned lim);
    if (inc && base < lim) return base + 1;
    return base;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, update the model, sample after the rising edge.
  task automatic step(bit req, bit done, bit beat, bit rd, bit wr, string tag);
    bit act;
    @(negedge clk);
    rd_req = req; rd_done = done; beat_vld = beat; reg_rd = rd; reg_wr = wr;
    #1;
    if (rd) check({tag, " read value (R5)"}, reg_rdata, exp_word());
    act    = req || (m_outst != 0);
    m_lat  = sat_add(rd ? 0 : m_lat, act, 65535);
    m_beat = sat_add(rd ? 0 : m_beat, beat, 255);
    m_outst = m_outst + (req ? 1 : 0) - (done ? 1 : 0);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_req = 0; rd_done = 0; beat_vld = 0; reg_rd = 0; reg_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset word", reg_rdata, 32'h0);

    // R2: request, two waits, completion -> four latency cycles
    step(1, 0, 0, 0, 0, "R2"); step(0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2"); step(0, 1, 0, 0, 0, "R2");
    idle(2);
    check("R2 four-cycle read", reg_rdata, 32'h0004_0000);
    step(0, 0, 0, 1, 0, "R2");
    check("R5 cleared after read", reg_rdata, 32'h0);

    // R2: same-cycle request and completion counts one
    step(1, 1, 0, 0, 0, "R2"); idle(1);
    check("R2 single-cycle read", reg_rdata, 32'h0001_0000);
    step(0, 0, 0, 1, 0, "R2");

    // R8: overlapping reads count once per clock
    step(1, 0, 0, 0, 0, "R8"); step(1, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, "R8"); step(0, 1, 0, 0, 0, "R8");
    idle(1);
    check("R8 overlap counts per clock", reg_rdata, 32'h0004_0000);
    step(0, 0, 0, 1, 0, "R8");

    // R4: beats
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, "R4");
    check("R4 five beats", reg_rdata, 32'h0000_0005);

    // R9: write with no events leaves word unchanged
    step(0, 0, 0, 0, 1, "R9");
    check("R9 write ignored", reg_rdata, 32'h0000_0005);

    // R7: read coinciding with a beat and a latency cycle
    step(1, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 1, 0, "R7");
    check("R7 coincident events kept", reg_rdata, 32'h0001_0001);
    step(0, 0, 0, 1, 0, "R7");
    check("R3 R5 zero word", reg_rdata, 32'h0);

    // R6: beat saturation
    for (int i = 0; i < 300; i++) step(0, 0, 1, 0, 0, "R6");
    check("R6 beat saturates", reg_rdata, 32'h0000_00FF);
    step(0, 0, 0, 1, 0, "R6");

    // R6: latency saturation
    step(1, 0, 0, 0, 0, "R6");
    idle(66000);
    step(0, 1, 0, 0, 0, "R6");
    check("R6 latency saturates", reg_rdata, 32'hFFFF_0000);
    step(0, 0, 0, 1, 0, "R6");

    // Random traffic within the input contract
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd2024);
      for (int i = 0; i < 4000; i++) begin
        bit r, d, b, rd, wr;
        r  = ($urandom % 4 == 0) && (m_outst < 15);
        d  = ($urandom % 3 == 0) && (m_outst != 0 || r);
        b  = ($urandom % 2 == 0);
        rd = ($urandom % 40 == 0);
        wr = ($urandom % 10 == 0);
        step(r, d, b, rd, wr, "R2 R3 R4 random");
        if (i % 97 == 0) check("R2 R3 R4 random word", reg_rdata, exp_word());
      end
    end
    while (m_outst != 0) step(0, 1, 0, 0, 0, "drain");
    check("R2 R4 final word", reg_rdata, exp_word());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule